// File: doc/BRIEF.md
# Per-Locality Interrupt Controller

This block keeps one interrupt-enable word and one interrupt-status word for each of several access localities. It drives a single level interrupt line. Event pulses come in from the command engine next to it. Each pulse carries a four-bit source vector and a locality tag. A source bit is latched into the tagged locality's status word only when that locality has both its master enable and the matching source enable set. The host clears status bits by writing ones to them.

Host register access is a simple synchronous write strobe with byte enables, plus a combinational read. Each access carries the locality that issued it. Reads are open to every valid locality. Enable and status writes take effect only when the issuing locality is the one currently marked active. A read-only vector register reports the interrupt line number fixed at elaboration. The polarity field in the enable word is stored for the pad driver outside the block. `irq_o` itself is an active-high "line asserted" flag.

Top module: `loc_irq_ctrl`

## Requirements
- R1: After reset, every locality's enable word reads 0x0000_0008 (polarity field bits 4:3 = 01, low level), every status word reads 0, and `irq_o` is 0.
- R2: Source bits map to status bits as follows: `evt_i[0]` to bit 0 (data ready), `evt_i[1]` to bit 1 (status valid), `evt_i[2]` to bit 2 (locality changed) and `evt_i[3]` to bit 7 (command ready). An event is latched when the tagged locality has enable bit 31 set and the matching source enable set. A latched event sets the status bit on the next clock edge and raises `irq_o` on that same edge.
- R3: An event whose source enable is clear, or whose locality has bit 31 clear, leaves the status word and `irq_o` unchanged.
- R4: An event tagged with a locality code of NUM_LOC or above is discarded.
- R5: Writing ones to status bits 0, 1, 2 or 7 clears them; other written bits are ignored. When such a write leaves that locality's status at zero, `irq_o` drops on the same edge, even if another locality still holds pending bits.
- R6: Enable and status writes whose access locality differs from `act_loc_i` change nothing. This includes the case where no locality is active.
- R7: An enable write stores only bit 31, bits 4:3, bit 7 and bits 2:0; all other bits read 0.
- R8: Bytes of the enable word whose byte-enable bit is 0 keep their previous value.
- R9: The vector register (select 2) reads IRQ_NUM from any valid locality; writes to it have no effect.
- R10: Reads with select 3, or with a locality code of NUM_LOC or above, return 0.
- R11: If an event and a clear hit the same status bit on the same edge, the bit ends set and `irq_o` stays high.
- R12: Events tagged for one locality never alter another locality's status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| act_loc_i | input | LOC_W | Currently active locality; NUM_LOC or above means none |
| evt_i | input | 4 | Event source pulses (data ready, status valid, locality changed, command ready) |
| evt_loc_i | input | LOC_W | Locality the event pulses are aimed at |
| wr_i | input | 1 | Register write strobe |
| acc_loc_i | input | LOC_W | Locality issuing the register access |
| sel_i | input | 2 | Register select: 0 enable, 1 status, 2 vector, 3 reserved |
| be_i | input | 4 | Byte enables for the write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected locality and register |
| irq_o | output | 1 | Interrupt line asserted |

## Verification
The bench targets these corner cases:
- Partial byte writes to the enable word. A design that ignored byte enables would wipe the master enable when only the low byte was written.
- Clears that leave some bits pending. A design that dropped the line on any clear would lose an interrupt that is still pending.
- Clears issued while another locality is active. A design that did not gate these would let a non-owner acknowledge interrupts.
- An event and a clear landing on one bit in the same cycle. A design that gave the clear priority would lose that event.
- Events tagged with an out-of-range locality. A design that did not check the tag would alias them onto a real locality.
- A clear of one locality while another locality still has pending bits. This pins down the rule that the line falls on the writer's status alone.

// File: rtl/loc_irq_pkg.sv
package loc_irq_pkg;

   localparam int REG_W   = 32;
   localparam int NUM_SRC = 4;
   localparam int GEN_BIT = 31;

   // status / enable bit positions for each source
   localparam int BIT_DRDY = 0;
   localparam int BIT_SVAL = 1;
   localparam int BIT_LCHG = 2;
   localparam int BIT_CRDY = 7;

   localparam logic [REG_W-1:0] SRC_MASK = (REG_W'(1) << BIT_DRDY) | (REG_W'(1) << BIT_SVAL)
                                         | (REG_W'(1) << BIT_LCHG) | (REG_W'(1) << BIT_CRDY);
   localparam logic [REG_W-1:0] POL_MASK = REG_W'(32'h0000_0018);
   localparam logic [REG_W-1:0] EN_KEEP  = SRC_MASK | POL_MASK | (REG_W'(1) << GEN_BIT);
   localparam logic [REG_W-1:0] EN_RST   = REG_W'(32'h0000_0008);

   typedef enum logic [1:0] {
      SEL_EN  = 2'd0,
      SEL_ST  = 2'd1,
      SEL_VEC = 2'd2,
      SEL_RSV = 2'd3
   } reg_sel_e;

   function automatic logic [REG_W-1:0] src_to_bits(input logic [NUM_SRC-1:0] s);
      logic [REG_W-1:0] r;
      r = '0;
      r[BIT_DRDY] = s[0];
      r[BIT_SVAL] = s[1];
      r[BIT_LCHG] = s[2];
      r[BIT_CRDY] = s[3];
      return r;
   endfunction

endpackage

// File: rtl/lic_evt_route.sv
module lic_evt_route
   import loc_irq_pkg::*;
#(
   parameter int NUM_LOC = 5,
   parameter int LOC_W   = 3
) (
   input  logic                             clk_i,
   input  logic                             rst_ni,
   input  logic [NUM_SRC-1:0]               evt_i,
   input  logic [LOC_W-1:0]                 evt_loc_i,
   output logic [NUM_LOC-1:0][REG_W-1:0]    evt_bits_o
);

   logic [REG_W-1:0] raw_bits;
   logic             loc_ok;

   assign raw_bits = src_to_bits(evt_i);
   assign loc_ok   = (evt_loc_i < LOC_W'(NUM_LOC));

   for (genvar g = 0; g < NUM_LOC; g++) begin : g_route
      assign evt_bits_o[g] = (loc_ok && evt_loc_i == LOC_W'(g)) ? raw_bits : '0;

      // R4
      bad_loc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (evt_loc_i >= LOC_W'(NUM_LOC)) |-> (evt_bits_o[g] == '0));

      // R12
      other_loc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (evt_loc_i != LOC_W'(g)) |-> (evt_bits_o[g] == '0));
   end

endmodule

// File: rtl/lic_loc_slot.sv
module lic_loc_slot
   import loc_irq_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_wr_i,
   input  logic             st_wr_i,
   input  logic [REG_W-1:0] wmask_i,
   input  logic [REG_W-1:0] wdata_i,
   input  logic [REG_W-1:0] evt_bits_i,
   output logic [REG_W-1:0] en_o,
   output logic [REG_W-1:0] st_o,
   output logic             latch_any_o,
   output logic             drop_o
);

   logic [REG_W-1:0] en_q, st_q;
   logic [REG_W-1:0] latch, clr, st_nxt, en_nxt;

   always_comb begin
      latch  = en_q[GEN_BIT] ? (evt_bits_i & en_q & SRC_MASK) : '0;
      clr    = st_wr_i ? (wdata_i & wmask_i & SRC_MASK) : '0;
      st_nxt = (st_q & ~clr) | latch;
      en_nxt = en_wr_i ? ((en_q & ~wmask_i) | (wdata_i & wmask_i & EN_KEEP)) : en_q;
   end

   assign latch_any_o = |latch;
   assign drop_o      = st_wr_i && (clr != '0) && (st_q != '0) && (st_nxt == '0);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         en_q <= EN_RST;
         st_q <= '0;
      end else begin
         en_q <= en_nxt;
         st_q <= st_nxt;
      end
   end

   assign en_o = en_q;
   assign st_o = st_q;

   // R6
   en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_wr_i |=> $stable(en_q));

   // R2
   st_gain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((st_q & ~$past(st_q) & ~($past(en_q[GEN_BIT]) ? $past(en_q) : '0)) == '0));

   // R7
   en_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_wr_i |=> ((en_q & ~EN_KEEP) == '0));

endmodule

// File: rtl/lic_line.sv
module lic_line #(
   parameter int NUM_LOC = 5
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_LOC-1:0] latch_i,
   input  logic [NUM_LOC-1:0] drop_i,
   output logic               irq_o
);

   logic irq_q, drop_any, latch_any;

   assign latch_any = |latch_i;
   assign drop_any  = |drop_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)        irq_q <= 1'b0;
      else if (latch_any) irq_q <= 1'b1;
      else if (drop_any)  irq_q <= 1'b0;
   end

   assign irq_o = irq_q;

   // R2
   irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      latch_any |=> irq_o);

   // R5
   irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_o) |-> $past(drop_any));

endmodule

// File: rtl/loc_irq_ctrl.sv
module loc_irq_ctrl
   import loc_irq_pkg::*;
#(
   parameter int NUM_LOC = 5,
   parameter int LOC_W   = 3,
   parameter int IRQ_NUM = 10
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [LOC_W-1:0]   act_loc_i,
   input  logic [3:0]         evt_i,
   input  logic [LOC_W-1:0]   evt_loc_i,
   input  logic               wr_i,
   input  logic [LOC_W-1:0]   acc_loc_i,
   input  logic [1:0]         sel_i,
   input  logic [3:0]         be_i,
   input  logic [31:0]        wdata_i,
   output logic [31:0]        rdata_o,
   output logic               irq_o
);

   localparam int NBYTE = REG_W / 8;

   if (IRQ_NUM < 0 || IRQ_NUM > 15) begin : g_bad_vec
      $error("IRQ_NUM must lie in 0..15");
   end
   if (NUM_LOC < 1 || NUM_LOC >= (1 << LOC_W)) begin : g_bad_loc
      $error("NUM_LOC must leave at least one unused locality code");
   end
   if (NBYTE != 4) begin : g_bad_w
      $error("register width must be four bytes");
   end

   logic [NUM_LOC-1:0][REG_W-1:0] evt_bits;
   logic [REG_W-1:0]              en_w [NUM_LOC];
   logic [REG_W-1:0]              st_w [NUM_LOC];
   logic [NUM_LOC-1:0]            latch_v, drop_v;
   logic [REG_W-1:0]              wmask;
   logic                          acc_ok;
   reg_sel_e                      sel;

   assign sel    = reg_sel_e'(sel_i);
   assign acc_ok = (acc_loc_i < LOC_W'(NUM_LOC)) && (acc_loc_i == act_loc_i);

   for (genvar b = 0; b < NBYTE; b++) begin : g_mask
      assign wmask[8*b +: 8] = {8{be_i[b]}};
   end

   lic_evt_route #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) i_route (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_i),
      .evt_loc_i  (evt_loc_i),
      .evt_bits_o (evt_bits)
   );

   for (genvar g = 0; g < NUM_LOC; g++) begin : g_slot
      logic hit;
      assign hit = wr_i && acc_ok && (acc_loc_i == LOC_W'(g));

      lic_loc_slot i_slot (
         .clk_i       (clk_i),
         .rst_ni      (rst_ni),
         .en_wr_i     (hit && sel == SEL_EN),
         .st_wr_i     (hit && sel == SEL_ST),
         .wmask_i     (wmask),
         .wdata_i     (wdata_i),
         .evt_bits_i  (evt_bits[g]),
         .en_o        (en_w[g]),
         .st_o        (st_w[g]),
         .latch_any_o (latch_v[g]),
         .drop_o      (drop_v[g])
      );
   end

   lic_line #(.NUM_LOC(NUM_LOC)) i_line (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .latch_i (latch_v),
      .drop_i  (drop_v),
      .irq_o   (irq_o)
   );

   always_comb begin
      rdata_o = '0;
      for (int g = 0; g < NUM_LOC; g++) begin
         if (acc_loc_i == LOC_W'(g)) begin
            unique case (sel)
               SEL_EN:  rdata_o = en_w[g];
               SEL_ST:  rdata_o = st_w[g];
               SEL_VEC: rdata_o = REG_W'(IRQ_NUM);
               default: rdata_o = '0;
            endcase
         end
      end
   end

   // R6
   inactive_st_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !acc_ok) |-> (drop_v == '0));

endmodule

// File: tb/test_loc_irq_ctrl.sv
module test_loc_irq_ctrl;

   localparam int IRQ_NUM = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  act_loc = 3'd7;
   logic [3:0]  evt = '0;
   logic [2:0]  evt_loc = '0;
   logic        wr = 1'b0;
   logic [2:0]  acc_loc = '0;
   logic [1:0]  sel = '0;
   logic [3:0]  be = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   loc_irq_ctrl #(.IRQ_NUM(IRQ_NUM)) i_loc_irq_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .act_loc_i(act_loc), .evt_i(evt), .evt_loc_i(evt_loc),
      .wr_i(wr), .acc_loc_i(acc_loc), .sel_i(sel), .be_i(be), .wdata_i(wdata),
      .rdata_o(rdata), .irq_o(irq)
   );

   localparam logic [2:0] OP_ACT = 3'd0, OP_WR = 3'd1, OP_EVT = 3'd2, OP_RD = 3'd3, OP_IRQ = 3'd4;
   // fields: op, loc, sel, be, data, expected, requirement
   localparam int NV = 46;
   localparam logic [79:0] VEC [NV] = '{
      {OP_ACT, 3'd0, 2'd0, 4'h0, 32'h0,          32'h0,          4'd0},
      {OP_WR,  3'd0, 2'd0, 4'hF, 32'hFFFF_FFFF,  32'h0,          4'd0},
      {OP_RD,  3'd0, 2'd0, 4'h0, 32'h0,          32'h8000_009F,  4'd7},  // R7
      {OP_EVT, 3'd0, 2'd0, 4'h0, 32'h1,          32'h0,          4'd0},
      {OP_RD,  3'd0, 2'd1, 4'h0, 32'h0,          32'h1,          4'd2},  // R2
      {OP_IRQ, 3'd0, 2'd0, 4'h0, 32'h0,          32'h1,          4'd2},  // R2
      {OP_EVT, 3'd0, 2'd0, 4'h0, 32'h8,          32'h0,          4'd0},
      {OP_RD,  3'd0, 2'd1, 4'h0, 32'h0,          32'h81,         4'd2},  // R2
      {OP_WR,  3'd0, 2'd1, 4'hF, 32'h80,         32'h0,          4'd0},
      {OP_RD,  3'd0, 2'd1, 4'h0, 32'h0,          32'h1,          4'd5},  // R5
      {OP_IRQ, 3'd0, 2'd0, 4'h0, 32'h0,          32'h1,          4'd5},  // R5
      {OP_WR,  3'd0, 2'd1, 4'hF, 32'hFFFF_FF7E,  32'h0,          4'd0},
      {OP_RD,  3'd0, 2'd1, 4'h0, 32'h0,          32'h1,          4'd5},  // R5
      {OP_WR,  3'd0, 2'd1, 4'hF, 32'h1,          32'h0,          4'd0},
      {OP_RD,  3'd0, 2'd1, 4'h0, 32'h0,          32'h0,          4'd5},  // R5
      {OP_IRQ, 3'd0, 2'd0, 4'h0, 32'h0,          32'h0,          4'd5},  // R5
      {OP_WR,  3'd0, 2'd0, 4'h1, 32'h0,          32'h0,          4'd0},
      {OP_RD,  3'd0, 2'd0, 4'h0, 32'h0,          32'h8000_0000,  4'd8},  // R8
      {OP_EVT, 3'd0, 2'd0, 4'h0, 32'hF,          32'h0,          4'd0},
      {OP_RD,  3'd0, 2'd1, 4'h0, 32'h0,          32'h0,          4'd3},  // R3
      {OP_IRQ, 3'd0, 2'd0, 4'h0, 32'h0,          32'h0,          4'd3},  // R3
      {OP_WR,  3'd0, 2'd0, 4'h8, 32'h0,          32'h0,          4'd0},
      {OP_WR,  3'd0, 2'd0, 4'h1, 32'h87,         32'h0,          4'd0},
      {OP_RD,  3'd0, 2'd0, 4'h0, 32'h0,          32'h87,         4'd8},  // R8
      {OP_EVT, 3'd0, 2'd0, 4'h0, 32'hF,          32'h0,          4'd0},
      {OP_RD,  3'd0, 2'd1, 4'h0, 32'h0,          32'h0,          4'd3},  // R3
      {OP_WR,  3'd1, 2'd0, 4'hF, 32'hFFFF_FFFF,  32'h0,          4'd0},
      {OP_RD,  3'd1, 2'd0, 4'h0, 32'h0,          32'h8,          4'd6},  // R6
      {OP_WR,  3'd0, 2'd0, 4'hF, 32'hFFFF_FFFF,  32'h0,          4'd0},
      {OP_EVT, 3'd5, 2'd0, 4'h0, 32'hF,          32'h0,          4'd0},
      {OP_IRQ, 3'd0, 2'd0, 4'h0, 32'h0,          32'h0,          4'd4},  // R4
      {OP_RD,  3'd0, 2'd1, 4'h0, 32'h0,          32'h0,          4'd4},  // R4
      {OP_RD,  3'd0, 2'd2, 4'h0, 32'h0,          32'(IRQ_NUM),   4'd9},  // R9
      {OP_WR,  3'd0, 2'd2, 4'hF, 32'h3,          32'h0,          4'd0},
      {OP_RD,  3'd3, 2'd2, 4'h0, 32'h0,          32'(IRQ_NUM),   4'd9},  // R9
      {OP_RD,  3'd0, 2'd3, 4'h0, 32'h0,          32'h0,          4'd10}, // R10
      {OP_RD,  3'd6, 2'd0, 4'h0, 32'h0,          32'h0,          4'd10}, // R10
      {OP_EVT, 3'd0, 2'd0, 4'h0, 32'h4,          32'h0,          4'd0},
      {OP_RD,  3'd0, 2'd1, 4'h0, 32'h0,          32'h4,          4'd2},  // R2
      {OP_ACT, 3'd1, 2'd0, 4'h0, 32'h0,          32'h0,          4'd0},
      {OP_WR,  3'd0, 2'd1, 4'hF, 32'hFFFF_FFFF,  32'h0,          4'd0},
      {OP_RD,  3'd0, 2'd1, 4'h0, 32'h0,          32'h4,          4'd6},  // R6
      {OP_IRQ, 3'd0, 2'd0, 4'h0, 32'h0,          32'h1,          4'd6},  // R6
      {OP_ACT, 3'd0, 2'd0, 4'h0, 32'h0,          32'h0,          4'd0},
      {OP_WR,  3'd0, 2'd1, 4'h1, 32'hFF,         32'h0,          4'd0},
      {OP_IRQ, 3'd0, 2'd0, 4'h0, 32'h0,          32'h0,          4'd5}   // R5
   };

   task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL R%0d: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_op(input logic [2:0] op, input logic [2:0] loc, input logic [1:0] s,
                        input logic [3:0] b, input logic [31:0] d, input logic [3:0] m);
      @(negedge clk);
      wr = (op == OP_WR);
      acc_loc = loc; sel = s; be = b; wdata = d;
      if (op == OP_EVT || m != 0) begin
         evt = (op == OP_EVT) ? d[3:0] : m;
         evt_loc = loc;
      end
      @(negedge clk);
      wr = 1'b0; evt = '0;
   endtask

   task automatic rd_chk(input int req, input logic [2:0] loc, input logic [1:0] s, input logic [31:0] exp);
      acc_loc = loc; sel = s;
      #1;
      check(req, rdata, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int g = 0; g < 5; g++) begin
         rd_chk(1, 3'(g), 2'd0, 32'h8);
         rd_chk(1, 3'(g), 2'd1, 32'h0);
      end
      check(1, {31'd0, irq}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         logic [2:0] op, loc; logic [1:0] s; logic [3:0] b, req; logic [31:0] d, e;
         {op, loc, s, b, d, e, req} = VEC[i];
         case (op)
            OP_ACT: begin @(negedge clk); act_loc = loc; end
            OP_WR, OP_EVT: do_op(op, loc, s, b, d, 4'h0);
            OP_RD: rd_chk(int'(req), loc, s, e);
            default: check(int'(req), {31'd0, irq}, e);
         endcase
      end

      // R12: event for locality 2 leaves locality 0 alone
      @(negedge clk); act_loc = 3'd2;
      do_op(OP_WR, 3'd2, 2'd0, 4'hF, 32'hFFFF_FFFF, 4'h0);
      do_op(OP_EVT, 3'd2, 2'd0, 4'h0, 32'h2, 4'h0);
      rd_chk(12, 3'd0, 2'd1, 32'h0);
      rd_chk(12, 3'd2, 2'd1, 32'h2);
      // R5: clearing locality 0 drops the line although locality 2 is pending
      @(negedge clk); act_loc = 3'd0;
      do_op(OP_EVT, 3'd0, 2'd0, 4'h0, 32'h1, 4'h0);
      check(5, {31'd0, irq}, 32'h1);
      do_op(OP_WR, 3'd0, 2'd1, 4'hF, 32'h1, 4'h0);
      check(5, {31'd0, irq}, 32'h0);
      rd_chk(5, 3'd2, 2'd1, 32'h2);
      // R11: event and clear on the same bit in one cycle
      do_op(OP_EVT, 3'd0, 2'd0, 4'h0, 32'h1, 4'h0);
      do_op(OP_WR, 3'd0, 2'd1, 4'hF, 32'h1, 4'h1);
      rd_chk(11, 3'd0, 2'd1, 32'h1);
      check(11, {31'd0, irq}, 32'h1);
      do_op(OP_WR, 3'd0, 2'd1, 4'hF, 32'h1, 4'h2);
      rd_chk(11, 3'd0, 2'd1, 32'h2);
      check(11, {31'd0, irq}, 32'h1);
      // R4: out-of-range tag while locality 0 fully enabled
      do_op(OP_EVT, 3'd7, 2'd0, 4'h0, 32'hF, 4'h0);
      rd_chk(4, 3'd0, 2'd1, 32'h2);
      // R6: no active locality blocks writes
      @(negedge clk); act_loc = 3'd7;
      do_op(OP_WR, 3'd0, 2'd1, 4'hF, 32'hFFFF_FFFF, 4'h0);
      rd_chk(6, 3'd0, 2'd1, 32'h2);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule